// File: doc/BRIEF.md
# Accumulator I/O-Page and Absolute Transfer Sequencer

This block sequences single-byte transfers between the accumulator and memory for a small 8-bit CPU. The core pulses `start` with a transfer code and the current values of C, H:L and the accumulator. The block then pulls zero, one or two operand bytes from the instruction stream over a request/valid handshake and forms the target address. It issues one memory read or write and holds it until the memory acknowledges. It then pulses `done`, and for loads it returns the fetched byte to the accumulator.

There are three ways to form the address. In the I/O-page forms the high byte is all ones and the low byte comes from C or from one immediate byte. In the absolute form two immediate bytes give the address, low byte first. A further form writes an immediate byte to the location held in H:L. C, H:L and the accumulator are sampled when `start` is taken, so later changes on those inputs do not affect a transfer that is already running.

Top module: `acc_xfer_unit`

## Requirements
- R1: Codes 0 (load) and 1 (store) address 0xFF00 | C and request no operand bytes.
- R2: Codes 2 (load) and 3 (store) take exactly one operand byte n and address 0xFF00 | n.
- R3: Codes 4 (load) and 5 (store) take exactly two operand bytes, low byte first, and address (high << 8) | low.
- R4: Store codes (1, 3, 5) raise `mem_wr` with the accumulator value sampled at `start` on `mem_wdata`. Load codes (0, 2, 4) raise `mem_rd`.
- R5: For a load, `acc_we` pulses together with `done`, and `acc_wdata` carries the byte returned with `mem_ack`. For a store, `acc_we` stays low.
- R6: Code 6 takes one operand byte and writes it to the H:L address sampled at `start`.
- R7: Each accepted transfer issues exactly one memory transaction. `done` is high for exactly the one cycle after the clock edge at which `mem_ack` is taken.
- R8: `mem_rd` and `mem_wr` are never high together, and neither is high while `imm_req` is high. Address, direction and write data stay unchanged until `mem_ack`.
- R9: `start` is ignored while `busy` is high, and code 7 is ignored: it produces no request and no `done`.
- R10: After reset, `busy`, `imm_req`, `mem_rd`, `mem_wr`, `done` and `acc_we` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a transfer (taken only when idle) |
| op | input | 3 | Transfer code 0..7 |
| reg_c | input | 8 | Value of register C |
| reg_hl | input | 16 | Value of register pair H:L |
| acc_in | input | 8 | Current accumulator value |
| imm_req | output | 1 | Operand byte wanted from the instruction stream |
| imm_vld | input | 1 | Operand byte present; taken when `imm_req` is also high |
| imm_byte | input | 8 | Operand byte |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory completes the request |
| acc_we | output | 1 | Accumulator write enable |
| acc_wdata | output | 8 | Accumulator write value |
| done | output | 1 | Transfer finished |
| busy | output | 1 | Transfer in progress |

## Verification
A wrong stored operand code or address register shows on `mem_addr` or on the choice between `mem_rd` and `mem_wr` at the first cycle of the request, one or two edges after the last operand byte is taken. A sequencer stuck in a fetch phase shows as an extra or missing `imm_req` cycle, or as a request that never comes. A broken return path shows in the `done` cycle as a wrong `acc_we` or `acc_wdata`, or as `done` arriving at the wrong time. The sweep changes the handshake latencies so that a wrong hold or wrong sampling time cannot coincide with the expected value.

// File: rtl/acc_xfer_unit.sv
module acc_xfer_unit #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [2:0]      op,
  input  logic [DW-1:0]   reg_c,
  input  logic [2*DW-1:0] reg_hl,
  input  logic [DW-1:0]   acc_in,
  output logic            imm_req,
  input  logic            imm_vld,
  input  logic [DW-1:0]   imm_byte,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic [2*DW-1:0] mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_ack,
  output logic            acc_we,
  output logic [DW-1:0]   acc_wdata,
  output logic            done,
  output logic            busy
);
  localparam int AW = 2 * DW;
  localparam logic [DW-1:0] PAGE = {DW{1'b1}};

  typedef enum logic [1:0] {S_IDLE, S_OPLO, S_OPHI, S_XFER} st_t;

  st_t            st;
  logic [2:0]     op_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q;
  logic           done_q;
  logic           we_q;
  logic [DW-1:0]  rbyte_q;
  logic           is_load;
  logic           take;

  assign is_load   = (op_q[0] == 1'b0) && (op_q != 3'd6);
  assign take      = imm_req && imm_vld;
  assign imm_req   = (st == S_OPLO) || (st == S_OPHI);
  assign mem_rd    = (st == S_XFER) && is_load;
  assign mem_wr    = (st == S_XFER) && !is_load;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign acc_we    = we_q;
  assign acc_wdata = rbyte_q;
  assign done      = done_q;
  assign busy      = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      op_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      done_q  <= 1'b0;
      we_q    <= 1'b0;
      rbyte_q <= '0;
    end else begin
      done_q <= 1'b0;
      we_q   <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start && op != 3'd7) begin
            op_q    <= op;
            wdata_q <= acc_in;
            case (op)
              3'd0, 3'd1: begin
                addr_q <= {PAGE, reg_c};
                st     <= S_XFER;
              end
              3'd2, 3'd3: begin
                addr_q[AW-1:DW] <= PAGE;
                st              <= S_OPLO;
              end
              3'd6: begin
                addr_q <= reg_hl;
                st     <= S_OPLO;
              end
              default: st <= S_OPLO;
            endcase
          end
        end
        S_OPLO: begin
          if (take) begin
            if (op_q == 3'd6) begin
              wdata_q <= imm_byte;
              st      <= S_XFER;
            end else begin
              addr_q[DW-1:0] <= imm_byte;
              st <= (op_q[2:1] == 2'b10) ? S_OPHI : S_XFER;
            end
          end
        end
        S_OPHI: begin
          if (take) begin
            addr_q[AW-1:DW] <= imm_byte;
            st              <= S_XFER;
          end
        end
        S_XFER: begin
          if (mem_ack) begin
            done_q  <= 1'b1;
            we_q    <= is_load;
            rbyte_q <= mem_rdata;
            st      <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module acc_xfer_unit_chk #(
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [2:0]      op_q,
  input logic            imm_req,
  input logic            mem_rd,
  input logic            mem_wr,
  input logic [2*DW-1:0] mem_addr,
  input logic [DW-1:0]   mem_wdata,
  input logic            mem_ack,
  input logic            acc_we,
  input logic            done,
  input logic            busy
);
  p_rw_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  p_fetch_not_mem_r8: assert property (@(posedge clk) disable iff (!rst_n)
    imm_req |-> !(mem_rd || mem_wr));

  p_hold_until_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) && !mem_ack |=>
      $stable(mem_addr) && $stable(mem_rd) && $stable(mem_wr) && $stable(mem_wdata));

  p_done_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) && mem_ack |=> done && !mem_rd && !mem_wr);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_io_page_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) && !op_q[2] |-> mem_addr[2*DW-1:DW] == {DW{1'b1}});

  p_accwe_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_we |-> done);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !imm_req && !mem_rd && !mem_wr);
endmodule

bind acc_xfer_unit acc_xfer_unit_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_q(op_q), .imm_req(imm_req),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack), .acc_we(acc_we),
  .done(done), .busy(busy)
);

// File: tb/test_acc_xfer_unit.sv
module test_acc_xfer_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [7:0]  reg_c = '0;
  logic [15:0] reg_hl = '0;
  logic [7:0]  acc_in = '0;
  logic        imm_req;
  logic        imm_vld = 1'b0;
  logic [7:0]  imm_byte = '0;
  logic        mem_rd, mem_wr;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic        acc_we;
  logic [7:0]  acc_wdata;
  logic        done, busy;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_xfer_unit i_acc_xfer_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .reg_c(reg_c),
    .reg_hl(reg_hl), .acc_in(acc_in), .imm_req(imm_req), .imm_vld(imm_vld),
    .imm_byte(imm_byte), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .acc_we(acc_we), .acc_wdata(acc_wdata), .done(done), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG) begin
      check(1'b0, "R7", "watchdog expired", cyc, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic run_op(input logic [2:0] code, input logic [7:0] c,
                        input logic [15:0] hl, input logic [7:0] a,
                        input logic [7:0] b0, input logic [7:0] b1,
                        input logic [7:0] rdat, input int ilat, input int mlat);
    logic [15:0] exp_addr;
    int   exp_fetch;
    bit   ld;
    logic [7:0] exp_wd;
    string rq;
    int   nfetch = 0, nreq = 0, icnt = 0, mcnt = 0;
    bit   in_req = 0, ack_was = 0, got_done = 0;
    case (code)
      3'd0, 3'd1: begin exp_addr = {8'hFF, c};  exp_fetch = 0; rq = "R1"; end
      3'd2, 3'd3: begin exp_addr = {8'hFF, b0}; exp_fetch = 1; rq = "R2"; end
      3'd4, 3'd5: begin exp_addr = {b1, b0};    exp_fetch = 2; rq = "R3"; end
      default:    begin exp_addr = hl;          exp_fetch = 1; rq = "R6"; end
    endcase
    ld     = (code == 3'd0) || (code == 3'd2) || (code == 3'd4);
    exp_wd = (code == 3'd6) ? b0 : a;

    @(negedge clk);
    start = 1'b1; op = code; reg_c = c; reg_hl = hl; acc_in = a;
    @(negedge clk);
    // stray start while busy (R9), operand inputs scrambled to test sampling
    op = 3'd1; reg_c = ~c; reg_hl = ~hl; acc_in = ~a;
    for (int k = 0; k < 80 && !got_done; k++) begin
      if (k > 0) begin
        @(negedge clk);
        start = 1'b0;
      end
      if (ack_was) begin
        check(done === 1'b1, "R7", "done after ack", done, 1);
        check(acc_we === ld, "R5", "acc_we", acc_we, ld);
        if (ld) check(acc_wdata === rdat, "R5", "acc_wdata", acc_wdata, rdat);
        got_done = 1;
      end
      imm_vld = 1'b0;
      mem_ack = 1'b0;
      if (!got_done) begin
        if (imm_req) begin
          if (icnt == ilat) begin
            imm_vld = 1'b1;
            imm_byte = (nfetch == 0) ? b0 : b1;
            nfetch++;
            icnt = 0;
          end else icnt++;
        end else if (mem_rd || mem_wr) begin
          if (!in_req) begin
            in_req = 1; nreq++;
            check(mem_addr === exp_addr, rq, "address", mem_addr, exp_addr);
            check(mem_rd === ld && mem_wr === !ld, "R4", "direction", {mem_rd, mem_wr}, {ld, !ld});
            if (!ld) check(mem_wdata === exp_wd, (code == 3'd6) ? "R6" : "R4", "write data", mem_wdata, exp_wd);
          end else begin
            check(mem_addr === exp_addr, "R8", "address held", mem_addr, exp_addr);
          end
          if (mcnt == mlat) begin
            mem_ack = 1'b1; mem_rdata = rdat; ack_was = 1;
          end else mcnt++;
        end
      end
    end
    start = 1'b0;
    check(got_done, "R7", "transfer completed", got_done, 1);
    check(nfetch == exp_fetch, rq, "operand byte count", nfetch, exp_fetch);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (mem_rd || mem_wr || imm_req || done) nreq++;
    end
    check(nreq == 1, "R7", "single transaction then quiet", nreq, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !imm_req && !mem_rd && !mem_wr && !done && !acc_we, "R10", "reset outputs",
          {busy, imm_req, mem_rd, mem_wr, done, acc_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // code 7 is ignored (R9)
    start = 1'b1; op = 3'd7;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 5; k++) begin
      check(!busy && !imm_req && !mem_rd && !mem_wr && !done, "R9", "code 7 ignored",
            {busy, imm_req, mem_rd, mem_wr, done}, 0);
      @(negedge clk);
    end

    for (int code = 0; code < 7; code++)
      for (int lat = 0; lat < 4; lat++)
        for (int p = 0; p < 6; p++) begin
          logic [7:0] c, a, b0, b1, rd;
          logic [15:0] hl;
          c  = 8'(p * 51 + lat * 7);
          a  = 8'(8'hA5 ^ (p * 37));
          b0 = 8'(p * 73 + 3);
          b1 = 8'(8'hFF - p * 29);
          rd = 8'(p * 17 + code);
          hl = {8'(p * 11 + 1), 8'(8'h80 + lat)};
          run_op(3'(code), c, hl, a, b0, b1, rd, lat, (lat * 3 + p) % 4);
        end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule